// File: doc/BRIEF.md
# Branch Target Line Cache

This block is a small, fully associative store of instruction lines that sits next to a prefetch unit in front of slow code flash. Each of its entries keeps a line address, a valid flag and one four-byte line of code. When a fetch request arrives, the block compares the request's line address with every valid entry at once. On a hit it returns the stored line, and the addressed byte, in the same cycle. On a miss it raises a miss flag so that the fetch unit goes to flash.

When the fetch unit later offers the line it read from flash, the block stores it. This happens only while the runtime enable input is high. The stored copy becomes visible on the next clock. The entry that receives a new line is chosen round-robin. A line that is already present is refreshed in its own entry and does not take a new one. A synchronous flush input drops every entry in a single cycle.

Top module: `btc_cache`

## Requirements
- R1: After reset no entry is valid, so every request reports a miss until a line has been stored.
- R2: On a hit, `line_o` carries the stored 32-bit line in the same cycle as the request. `byte_o` carries the byte chosen by address bits [1:0], where byte 0 is line bits [7:0] and byte 3 is bits [31:24].
- R3: `hit_o` and `miss_o` are never high together. `miss_o` is high exactly when `req_valid_i` is high and no valid entry matches. Both are low while `req_valid_i` is low.
- R4: The line address is request address bits [14:2]. Requests that differ only in bits [1:0] hit the same line. Requests that differ in any upper bit do not.
- R5: A fill offered with `fill_en_i` high stores the line and its data, and a request for that line hits from the next cycle on.
- R6: A fill offered while `fill_en_i` is low has no effect: the line stays absent, and the victim order does not advance.
- R7: New lines go to entries in round-robin order, starting at entry 0 after reset and wrapping after 32. The 33rd distinct line stored therefore evicts the first, and the 34th evicts the second.
- R8: A fill whose line address matches a valid entry rewrites that entry's data in place and does not advance the victim order.
- R9: A flush clears every entry in one cycle. If a fill is offered in the same cycle as a flush, the fill is dropped.
- R10: A request made in the same cycle as a fill of the same line sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate every entry |
| fill_en_i | input | 1 | Runtime permission to store fills |
| req_valid_i | input | 1 | Fetch request present |
| req_addr_i | input | 15 | Byte address of the fetch |
| hit_o | output | 1 | Request matched a valid entry |
| miss_o | output | 1 | Request matched no valid entry |
| line_o | output | 32 | Line of the matching entry, zero on a miss |
| byte_o | output | 8 | Addressed byte of the matching line |
| fill_valid_i | input | 1 | A line read from flash is offered |
| fill_line_i | input | 13 | Line address of the offered fill |
| fill_data_i | input | 32 | Four code bytes of the offered fill |

## Verification
The bench builds the block with its default parameters: 32 entries, a 15-bit address and four-byte lines. With that size, 34 distinct fills are enough to carry the victim pointer through a full wrap. That brings two orderings within reach: eviction of the oldest line, and the in-place refresh that must leave the pointer parked on the next victim. A behavioural model of the entry list is compared with the outputs on every request. This covers simultaneous fill-and-request, and flush colliding with a fill.

// File: rtl/btc_pkg.sv
package btc_pkg;
    localparam int BTC_ENTRIES    = 32;
    localparam int BTC_ADDR_W     = 15;
    localparam int BTC_LINE_BYTES = 4;
endpackage

// File: rtl/btc_tag_match.sv
module btc_tag_match #(
    parameter int N     = 32,
    parameter int TAG_W = 13
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]        key_i,
    output logic [N-1:0]            match_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
    end
endmodule

// File: rtl/btc_onehot_enc.sv
module btc_onehot_enc #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) idx_o = idx_o | IDX_W'(i);
        end
    end
    assign any_o = |vec_i;
endmodule

// File: rtl/btc_cache.sv
module btc_cache
    import btc_pkg::*;
#(
    parameter int N          = BTC_ENTRIES,
    parameter int ADDR_W     = BTC_ADDR_W,
    parameter int LINE_BYTES = BTC_LINE_BYTES
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   flush_i,
    input  logic                                   fill_en_i,
    input  logic                                   req_valid_i,
    input  logic [ADDR_W-1:0]                      req_addr_i,
    output logic                                   hit_o,
    output logic                                   miss_o,
    output logic [8*LINE_BYTES-1:0]                line_o,
    output logic [7:0]                             byte_o,
    input  logic                                   fill_valid_i,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   fill_line_i,
    input  logic [8*LINE_BYTES-1:0]                fill_data_i
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFS_W;
    localparam int LINE_W = 8 * LINE_BYTES;
    localparam int IDX_W  = $clog2(N);

    typedef struct packed {
        logic [N-1:0]             valid;
        logic [N-1:0][TAG_W-1:0]  tag;
        logic [N-1:0][LINE_W-1:0] data;
        logic [IDX_W-1:0]         ptr;
    } state_t;

    state_t state_d, state_q;

    logic [TAG_W-1:0] req_tag;
    logic [OFS_W-1:0] req_ofs;
    logic [N-1:0]     req_vec, fill_vec;
    logic             req_any, fill_any;
    logic [IDX_W-1:0] req_idx, fill_idx;
    logic [IDX_W-1:0] slot;

    assign req_tag = req_addr_i[ADDR_W-1:OFS_W];
    assign req_ofs = req_addr_i[OFS_W-1:0];

    btc_tag_match #(.N(N), .TAG_W(TAG_W)) u_req_match (
        .valid_i(state_q.valid), .tags_i(state_q.tag),
        .key_i(req_tag), .match_o(req_vec)
    );
    btc_onehot_enc #(.N(N), .IDX_W(IDX_W)) u_req_enc (
        .vec_i(req_vec), .any_o(req_any), .idx_o(req_idx)
    );
    btc_tag_match #(.N(N), .TAG_W(TAG_W)) u_fill_match (
        .valid_i(state_q.valid), .tags_i(state_q.tag),
        .key_i(fill_line_i), .match_o(fill_vec)
    );
    btc_onehot_enc #(.N(N), .IDX_W(IDX_W)) u_fill_enc (
        .vec_i(fill_vec), .any_o(fill_any), .idx_o(fill_idx)
    );

    assign hit_o  = req_valid_i && req_any;
    assign miss_o = req_valid_i && !req_any;
    assign line_o = req_any ? state_q.data[req_idx] : '0;
    assign byte_o = line_o[{req_ofs, 3'b000} +: 8];

    always_comb begin
        state_d = state_q;
        slot    = fill_any ? fill_idx : state_q.ptr;
        if (flush_i) begin
            state_d.valid = '0;
        end else if (fill_valid_i && fill_en_i) begin
            state_d.valid[slot] = 1'b1;
            state_d.tag[slot]   = fill_line_i;
            state_d.data[slot]  = fill_data_i;
            if (!fill_any) begin
                state_d.ptr = (state_q.ptr == IDX_W'(N - 1)) ? '0 : state_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/btc_cache_checks.sv
module btc_cache_checks #(
    parameter int N      = 32,
    parameter int TAG_W  = 13,
    parameter int LINE_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              fill_en_i,
    input logic              fill_valid_i,
    input logic [TAG_W-1:0]  fill_line_i,
    input logic [LINE_W-1:0] fill_data_i,
    input logic              req_valid_i,
    input logic [TAG_W-1:0]  req_line_i,
    input logic              hit_o,
    input logic              miss_o,
    input logic [LINE_W-1:0] line_o,
    input logic [N-1:0]      req_vec,
    input logic [IDX_W-1:0]  ptr
);
    a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && miss_o));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |-> (!hit_o && !miss_o));

    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec));

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !hit_o);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flush_i)) |-> !hit_o);

    a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_valid_i && fill_en_i && !flush_i)
         && req_valid_i && (req_line_i == $past(fill_line_i)))
        |-> (hit_o && line_o == $past(fill_data_i)));

    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fill_valid_i && fill_en_i)) |-> (ptr == $past(ptr)));

    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |->
        ((ptr == $past(ptr) + 1'b1) || ($past(ptr) == IDX_W'(N - 1) && ptr == '0)));
endmodule

bind btc_cache btc_cache_checks #(
    .N(N), .TAG_W(TAG_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
) u_checks (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fill_en_i(fill_en_i),
    .fill_valid_i(fill_valid_i), .fill_line_i(fill_line_i), .fill_data_i(fill_data_i),
    .req_valid_i(req_valid_i), .req_line_i(req_addr_i[ADDR_W-1:OFS_W]),
    .hit_o(hit_o), .miss_o(miss_o), .line_o(line_o),
    .req_vec(req_vec), .ptr(state_q.ptr)
);

// File: tb/btc_cache_test.sv
module btc_cache_test;
    localparam int NE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        fill_en_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [14:0] req_addr_i = '0;
    logic        hit_o, miss_o;
    logic [31:0] line_o;
    logic [7:0]  byte_o;
    logic        fill_valid_i = 1'b0;
    logic [12:0] fill_line_i = '0;
    logic [31:0] fill_data_i = '0;

    int tests = 0;
    int fails = 0;

    bit          mv[NE];
    logic [12:0] mt[NE];
    logic [31:0] md[NE];
    int          mp = 0;

    always #4 clk = ~clk;

    btc_cache uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fill_en_i(fill_en_i),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .hit_o(hit_o), .miss_o(miss_o), .line_o(line_o), .byte_o(byte_o),
        .fill_valid_i(fill_valid_i), .fill_line_i(fill_line_i), .fill_data_i(fill_data_i)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int lookup(input logic [12:0] t);
        for (int i = 0; i < NE; i++) if (mv[i] && mt[i] == t) return i;
        return -1;
    endfunction

    // Drive one cycle after a falling edge, compare, then advance the model.
    task automatic step(input string req, input bit rv, input logic [14:0] ra,
                        input bit fv, input logic [12:0] fl, input logic [31:0] fd,
                        input bit en, input bit fs);
        int j;
        req_valid_i = rv; req_addr_i = ra; fill_valid_i = fv;
        fill_line_i = fl; fill_data_i = fd; fill_en_i = en; flush_i = fs;
        #1;
        j = lookup(ra[14:2]);
        check(req, "hit", {31'b0, hit_o}, {31'b0, rv && j >= 0});
        check(req, "miss", {31'b0, miss_o}, {31'b0, rv && j < 0});
        if (rv && j >= 0) begin
            check(req, "line", line_o, md[j]);
            check(req, "byte", {24'b0, byte_o}, {24'b0, md[j][8*ra[1:0] +: 8]});
        end
        @(posedge clk);
        if (fs) begin
            for (int i = 0; i < NE; i++) mv[i] = 1'b0;
        end else if (fv && en) begin
            j = lookup(fl);
            if (j >= 0) md[j] = fd;
            else begin
                mv[mp] = 1'b1; mt[mp] = fl; md[mp] = fd; mp = (mp + 1) % NE;
            end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NE; i++) begin mv[i] = 0; mt[i] = '0; md[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        step("R1", 1, 15'h0100, 0, '0, '0, 0, 0);
        step("R1", 1, 15'h7FFC, 0, '0, '0, 0, 0);
        // R3: idle request drives neither flag
        step("R3", 0, 15'h0100, 0, '0, '0, 0, 0);
        // R6: disabled fill is ignored
        step("R6", 0, '0, 1, 13'h0040, 32'hDEADBEEF, 0, 0);
        step("R6", 1, 15'h0100, 0, '0, '0, 0, 0);
        // R5: enabled fill visible next cycle, lands in entry 0
        step("R5", 0, '0, 1, 13'h0040, 32'h44332211, 1, 0);
        // R2 / R4: every byte of the line, and a neighbouring line
        for (int b = 0; b < 4; b++) step("R2", 1, 15'h0100 + 15'(b), 0, '0, '0, 0, 0);
        step("R4", 1, 15'h0104, 0, '0, '0, 0, 0);
        step("R4", 1, 15'h4100, 0, '0, '0, 0, 0);
        // R10: request during a fill of the same line sees old contents
        step("R10", 1, 15'h0200, 1, 13'h0080, 32'hA5A50080, 1, 0);
        step("R10", 1, 15'h0202, 0, '0, '0, 0, 0);
        // R7: fill the rest of the array
        for (int i = 0; i < 30; i++)
            step("R7", 0, '0, 1, 13'h0400 + 13'(i), 32'hC0DE0000 + 32'(i), 1, 0);
        for (int i = 0; i < 30; i++) step("R7", 1, 15'h1000 + 15'(4 * i), 0, '0, '0, 0, 0);
        // R8: refresh the line in entry 0 in place; pointer stays at 0
        step("R8", 0, '0, 1, 13'h0040, 32'h99887766, 1, 0);
        step("R8", 1, 15'h0103, 0, '0, '0, 0, 0);
        // R7: 33rd distinct line evicts entry 0, 34th evicts entry 1
        step("R7", 0, '0, 1, 13'h0C00, 32'h33000001, 1, 0);
        step("R7", 1, 15'h0100, 0, '0, '0, 0, 0);
        step("R8", 1, 15'h0200, 0, '0, '0, 0, 0);
        step("R7", 1, 15'h3000, 0, '0, '0, 0, 0);
        step("R7", 0, '0, 1, 13'h0C01, 32'h33000002, 1, 0);
        step("R7", 1, 15'h0200, 0, '0, '0, 0, 0);
        step("R7", 1, 15'h1000, 0, '0, '0, 0, 0);
        // R9: flush beats a simultaneous fill
        step("R9", 1, 15'h3004, 1, 13'h1000, 32'h0F0F0F0F, 1, 1);
        step("R9", 1, 15'h4000, 0, '0, '0, 0, 0);
        step("R9", 1, 15'h3004, 0, '0, '0, 0, 0);
        step("R9", 1, 15'h1004, 0, '0, '0, 0, 0);
        // R5: storing works again after a flush
        step("R5", 0, '0, 1, 13'h1000, 32'h12345678, 1, 0);
        step("R5", 1, 15'h4001, 0, '0, '0, 0, 0);
        step("R3", 0, 15'h4001, 0, '0, '0, 0, 0);
        finish_run();
    end
endmodule